// File: doc/BRIEF.md
# Externally Filled Stream FIFO

This block is a stream FIFO whose storage array is filled from outside by a data mover, not through a push port. The consuming logic sees a simple pop interface: a data word, a flag that says words are waiting, and a pop strobe. The producer side is a controller that writes words straight into the storage through a dedicated write port. It then announces the new fill level by posting a new head pointer value.

To size a fill, the controller reads the live tail pointer from a status output. It computes the free space as the depth minus the distance from tail to head. A typical fill runs in four steps: set a source pointer, query space, move the words into storage while advancing the source pointer, then post the head. The block keeps both pointers, checks every posted head against the depth, produces the read address and flags, and handles pointer wrap.

Top module: `ext_fill_fifo`

## Requirements
- R1: After reset the tail status reads 0, the not-empty flag is low and the overflow error flag is low.
- R2: Pointers are ADDR_W+1 bits wide. The extra top bit is a wrap bit, and occupancy is (head - tail) modulo 2^(ADDR_W+1). The not-empty flag is high exactly when head and tail differ.
- R3: A head post whose resulting occupancy (posted value minus current tail, modulo 2^(ADDR_W+1)) is at most the depth of 2^ADDR_W words is accepted. It takes effect on the flags in the following cycle, so occupancy never exceeds the depth.
- R4: A head post whose resulting occupancy exceeds the depth is rejected and leaves the head unchanged. It also sets the error flag, which stays set until reset.
- R5: A pop while the FIFO holds words advances the tail by one, modulo 2^(ADDR_W+1), visible on the status output in the next cycle.
- R6: A pop while the FIFO is empty is ignored, and the tail status stays unchanged.
- R7: The data output shows the stored word at address tail[ADDR_W-1:0] one cycle after the tail last changed. During a pop, the next word is presented in the cycle after the pop.
- R8: A storage write to the address the read side fetches in that same cycle is forwarded, so the data output shows the newly written word in the next cycle.
- R9: When the tail passes the last address, the read address wraps to 0 and the wrap bit toggles. A buffer holding exactly 2^ADDR_W words reads as not empty, and it reads as empty once all of those words have been popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cons_pop_i | input | 1 | Consumer pop strobe |
| cons_data_o | output | DATA_W | Word at the current tail |
| cons_avail_o | output | 1 | FIFO is not empty |
| mem_we_i | input | 1 | Storage write enable from the data mover |
| mem_waddr_i | input | ADDR_W | Storage write address |
| mem_wdata_i | input | DATA_W | Storage write data |
| hd_post_valid_i | input | 1 | Head post strobe |
| hd_post_ptr_i | input | ADDR_W+1 | New head pointer value |
| stat_tail_o | output | ADDR_W+1 | Current tail pointer for space queries |
| ovf_err_o | output | 1 | Sticky rejected-post error |

## Verification
The first pattern is a short fill and drain: three words are written, the head is posted, and the words are popped. This shows whether the data ordering is right and whether the one-cycle read latency lines up with the tail. A pop on an empty FIFO, followed by posts one word beyond and exactly at the depth, separates the rejection rule from the full-but-legal case. A second run fills all 256 slots and drains them across the address boundary. It tells the wrap bit apart from the address bits, and a post that aliases past the tail shows that the head is left untouched after a rejection.

// File: rtl/efifo_pkg.sv
package efifo_pkg;
  localparam int unsigned EF_DATA_W = 32;
  localparam int unsigned EF_ADDR_W = 8;

  typedef enum logic [0:0] {
    POST_ACCEPT = 1'b0,
    POST_REJECT = 1'b1
  } post_verdict_e;
endpackage

// File: rtl/efifo_rst_sync.sv
module efifo_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/efifo_ptr_ctl.sv
module efifo_ptr_ctl
  import efifo_pkg::*;
#(
  parameter int unsigned ADDR_W = EF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              post_v_i,
  input  logic [ADDR_W:0]   post_ptr_i,
  output logic [ADDR_W:0]   head_o,
  output logic [ADDR_W:0]   tail_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              avail_o,
  output logic              err_o
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] ONE_P   = PTR_W'(1);

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic             err_q, err_d;
  logic             head_en, tail_en, err_en;
  logic [PTR_W-1:0] post_occ;
  post_verdict_e    verdict;
  logic             pop_go;

  // next-state logic
  always_comb begin
    avail_o  = (head_q != tail_q);
    pop_go   = pop_i & avail_o;
    post_occ = post_ptr_i - tail_q;
    verdict  = (post_occ <= DEPTH_P) ? POST_ACCEPT : POST_REJECT;

    tail_en  = pop_go;
    tail_d   = tail_q + ONE_P;

    head_en  = post_v_i & (verdict == POST_ACCEPT);
    head_d   = post_ptr_i;

    err_en   = post_v_i & (verdict == POST_REJECT);
    err_d    = 1'b1;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (head_en) head_q <= head_d;
      if (tail_en) tail_q <= tail_d;
      if (err_en)  err_q  <= err_d;
    end
  end

  // the read side fetches the word the tail will point at after this edge
  assign rd_addr_o = tail_en ? tail_d[ADDR_W-1:0] : tail_q[ADDR_W-1:0];
  assign head_o    = head_q;
  assign tail_o    = tail_q;
  assign err_o     = err_q;
endmodule

// File: rtl/efifo_store.sv
module efifo_store
  import efifo_pkg::*;
#(
  parameter int unsigned DATA_W = EF_DATA_W,
  parameter int unsigned ADDR_W = EF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              fwd_hit;

  always_comb begin
    fwd_hit = we_i & (waddr_i == raddr_i);
    rdata_d = fwd_hit ? wdata_i : mem_q[raddr_i];
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ext_fill_fifo.sv
module ext_fill_fifo
  import efifo_pkg::*;
#(
  parameter int unsigned DATA_W = EF_DATA_W,
  parameter int unsigned ADDR_W = EF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cons_pop_i,
  output logic [DATA_W-1:0] cons_data_o,
  output logic              cons_avail_o,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] mem_waddr_i,
  input  logic [DATA_W-1:0] mem_wdata_i,
  input  logic              hd_post_valid_i,
  input  logic [ADDR_W:0]   hd_post_ptr_i,
  output logic [ADDR_W:0]   stat_tail_o,
  output logic              ovf_err_o
);
  logic              rst_sync_n;
  logic [ADDR_W:0]   head_w;
  logic [ADDR_W-1:0] rd_addr_w;

  efifo_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  efifo_ptr_ctl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .pop_i      (cons_pop_i),
    .post_v_i   (hd_post_valid_i),
    .post_ptr_i (hd_post_ptr_i),
    .head_o     (head_w),
    .tail_o     (stat_tail_o),
    .rd_addr_o  (rd_addr_w),
    .avail_o    (cons_avail_o),
    .err_o      (ovf_err_o)
  );

  efifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (mem_we_i),
    .waddr_i (mem_waddr_i),
    .wdata_i (mem_wdata_i),
    .raddr_i (rd_addr_w),
    .rdata_o (cons_data_o)
  );
endmodule

// File: rtl/efifo_chk.sv
module efifo_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cons_pop_i,
  input logic              cons_avail_o,
  input logic [DATA_W-1:0] cons_data_o,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_waddr_i,
  input logic [DATA_W-1:0] mem_wdata_i,
  input logic              hd_post_valid_i,
  input logic [ADDR_W:0]   hd_post_ptr_i,
  input logic [ADDR_W:0]   stat_tail_o,
  input logic              ovf_err_o,
  input logic [ADDR_W:0]   head_q
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  logic [PTR_W-1:0] occ_w;
  logic [PTR_W-1:0] post_occ_w;
  assign occ_w      = head_q - stat_tail_o;
  assign post_occ_w = hd_post_ptr_i - stat_tail_o;

  // R3: occupancy held by the pointer pair never exceeds the depth
  p_occ_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_w <= DEPTH_P);

  // R4: an oversize post raises the error flag
  p_bad_post_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hd_post_valid_i && (post_occ_w > DEPTH_P)) |=> ovf_err_o);

  // R4: error flag is sticky
  p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o);

  // R5: a pop with words waiting steps the tail by one
  p_tail_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_pop_i && cons_avail_o) |=> (stat_tail_o == $past(stat_tail_o) + 1'b1));

  // R6: a pop on an empty FIFO leaves the tail alone
  p_empty_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_pop_i && !cons_avail_o) |=> $stable(stat_tail_o));

  // R5: without a pop the tail does not move
  p_tail_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cons_pop_i |=> $stable(stat_tail_o));

  // R8: a write to the tail address while idle is forwarded to the data output
  p_fwd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && !cons_pop_i && (mem_waddr_i == stat_tail_o[ADDR_W-1:0]))
      |=> (cons_data_o == $past(mem_wdata_i)));
endmodule

bind ext_fill_fifo efifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_sync_n),
  .cons_pop_i      (cons_pop_i),
  .cons_avail_o    (cons_avail_o),
  .cons_data_o     (cons_data_o),
  .mem_we_i        (mem_we_i),
  .mem_waddr_i     (mem_waddr_i),
  .mem_wdata_i     (mem_wdata_i),
  .hd_post_valid_i (hd_post_valid_i),
  .hd_post_ptr_i   (hd_post_ptr_i),
  .stat_tail_o     (stat_tail_o),
  .ovf_err_o       (ovf_err_o),
  .head_q          (head_w)
);

// File: tb/sim_ext_fill_fifo.sv
module sim_ext_fill_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int WDOG_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pop;
  logic [DATA_W-1:0] data;
  logic              avail;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic              pv;
  logic [ADDR_W:0]   pp;
  logic [ADDR_W:0]   tail;
  logic              err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ext_fill_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .cons_pop_i      (pop),
    .cons_data_o     (data),
    .cons_avail_o    (avail),
    .mem_we_i        (we),
    .mem_waddr_i     (waddr),
    .mem_wdata_i     (wdata),
    .hd_post_valid_i (pv),
    .hd_post_ptr_i   (pp),
    .stat_tail_o     (tail),
    .ovf_err_o       (err)
  );

  typedef struct packed {
    logic        pop;
    logic        we;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic        pv;
    logic [8:0]  pp;
    logic        e_av;
    logic [8:0]  e_tl;
    logic        e_err;
    logic        chk_d;
    logic [31:0] e_d;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 8'd0, 32'h1111_0000, 1'b0, 9'd0,   1'b0, 9'd0, 1'b0, 1'b1, 32'h1111_0000},
    '{1'b0, 1'b1, 8'd1, 32'h2222_0001, 1'b0, 9'd0,   1'b0, 9'd0, 1'b0, 1'b1, 32'h1111_0000},
    '{1'b0, 1'b1, 8'd2, 32'h3333_0002, 1'b1, 9'd3,   1'b1, 9'd0, 1'b0, 1'b1, 32'h1111_0000},
    '{1'b1, 1'b0, 8'd0, 32'h0,         1'b0, 9'd0,   1'b1, 9'd1, 1'b0, 1'b1, 32'h2222_0001},
    '{1'b1, 1'b0, 8'd0, 32'h0,         1'b0, 9'd0,   1'b1, 9'd2, 1'b0, 1'b1, 32'h3333_0002},
    '{1'b1, 1'b0, 8'd0, 32'h0,         1'b0, 9'd0,   1'b0, 9'd3, 1'b0, 1'b0, 32'h0},
    '{1'b1, 1'b0, 8'd0, 32'h0,         1'b0, 9'd0,   1'b0, 9'd3, 1'b0, 1'b0, 32'h0},
    '{1'b0, 1'b0, 8'd0, 32'h0,         1'b1, 9'd260, 1'b0, 9'd3, 1'b1, 1'b0, 32'h0},
    '{1'b0, 1'b0, 8'd0, 32'h0,         1'b1, 9'd259, 1'b1, 9'd3, 1'b1, 1'b0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic v, input logic [8:0] hp);
    pop = p; we = w; waddr = a; wdata = d; pv = v; pp = hp;
    @(negedge clk);
    pop = 1'b0; we = 1'b0; waddr = '0; wdata = '0; pv = 1'b0; pp = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    pop = 1'b0; we = 1'b0; waddr = '0; wdata = '0; pv = 1'b0; pp = '0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    check("R1 avail", 32'(avail), 32'd0);
    check("R1 tail",  32'(tail),  32'd0);
    check("R1 err",   32'(err),   32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].pop, VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].pv, VEC[i].pp);
      check($sformatf("R2 avail vec%0d", i), 32'(avail), 32'(VEC[i].e_av));
      check($sformatf("R5/R6 tail vec%0d", i), 32'(tail), 32'(VEC[i].e_tl));
      check($sformatf("R3/R4 err vec%0d", i), 32'(err), 32'(VEC[i].e_err));
      if (VEC[i].chk_d)
        check($sformatf("R7/R8 data vec%0d", i), data, VEC[i].e_d);
    end

    // R1: reset clears the sticky error
    do_reset();
    check("R1 err after reset", 32'(err), 32'd0);
    check("R1 tail after reset", 32'(tail), 32'd0);

    // R9: full buffer and wrap
    drive(1'b0, 1'b1, 8'd255, 32'hAAAA_00FF, 1'b0, 9'd0);
    drive(1'b0, 1'b1, 8'd0,   32'hBBBB_0000, 1'b0, 9'd0);
    drive(1'b0, 1'b0, 8'd0,   32'h0,         1'b1, 9'd256);
    check("R9 full avail", 32'(avail), 32'd1);
    check("R3 full err", 32'(err), 32'd0);
    check("R7 data at tail 0", data, 32'hBBBB_0000);
    for (int k = 0; k < 255; k++) drive(1'b1, 1'b0, 8'd0, 32'h0, 1'b0, 9'd0);
    check("R5 tail 255", 32'(tail), 32'd255);
    check("R7 data at 255", data, 32'hAAAA_00FF);
    drive(1'b1, 1'b0, 8'd0, 32'h0, 1'b0, 9'd0);
    check("R9 tail wrap bit", 32'(tail), 32'd256);
    check("R9 drained empty", 32'(avail), 32'd0);
    check("R9 wrapped read", data, 32'hBBBB_0000);
    drive(1'b0, 1'b0, 8'd0, 32'h0, 1'b1, 9'd257);
    check("R3 post after wrap", 32'(avail), 32'd1);
    drive(1'b0, 1'b0, 8'd0, 32'h0, 1'b1, 9'd1);
    check("R4 aliased post err", 32'(err), 32'd1);
    check("R4 avail kept", 32'(avail), 32'd1);
    drive(1'b1, 1'b0, 8'd0, 32'h0, 1'b0, 9'd0);
    check("R4 head unchanged", 32'(avail), 32'd0);
    check("R5 tail 257", 32'(tail), 32'd257);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule